// File: doc/BRIEF.md
# Dual-Mechanism Configuration Access Decoder

This block turns host I/O cycles into configuration-space requests for up to 32 device slots. Two access methods are supported, and a mode port picks which one is active at run time. In the first method, software writes a 32-bit target word (register offset, function, device, bus, enable) to an address latch. It then moves bytes through a four-byte data window. In the second, older method, software writes a non-zero key together with a function number. A 4 KiB I/O range then opens, and each address in that range names a device (address bits 11:8) and a register (address bits 7:0).

Every decoded access becomes a request carrying bus, device, function, register byte address, direction and write byte. Before the request is issued, the bus number is translated to a bus index through one table, and the index and device number are translated to a physical slot through a second table. If an access lands on no slot, or on an empty slot, it produces no request and reads all ones. The slot's read byte is passed back to the host in the same cycle.

Top module: `cfg_access_decoder`

## Requirements
- R1: After reset the second method is active, the mode port (0xCFB) reads 0x00, and the key, function, bus, register offset, device and enable state are all zero. The bus table maps bus 0 to index 0 and every other bus to 0xFF (unmapped). Every device-table entry is 0xFF.
- R2: With the first method active, a 32-bit write to 0xCF8 stores the register offset from bits 7:0, the function from bits 10:8, the device from bits 15:11, the bus from bits 23:16 and the enable from bit 31. A 32-bit read of 0xCF8 returns these fields in the same positions, with bits 30:24 reading zero.
- R3: With the first method active and enable set, a byte access to 0xCFC+n (n = 0..3) issues a one-cycle request in the same cycle. The request carries the latched bus, device and function, and a register address equal to the latched offset ORed with n. A read returns the slot's byte in bits 7:0 of the read data, with bits 31:8 all ones.
- R4: With the first method active and enable clear, byte reads of 0xCFC..0xCFF return 0xFF and no request is issued for reads or writes.
- R5: With the second method active, a byte write to 0xCF8 sets the function from bits 3:1 and the key from bits 7:4. A byte read of 0xCF8 returns the key in bits 7:4 and the function in bits 3:1, with bit 0 zero.
- R6: With the second method active, port 0xCFA holds the bus number (byte write and byte read). While the key is non-zero, a byte access anywhere in 0xC000..0xCFFF other than 0xCF8..0xCFB issues a request with device = address bits 11:8 and register = address bits 7:0. While the key is zero, such accesses read 0xFF and issue nothing.
- R7: Port 0xCFB bit 0 selects the first method when 1 and the second method when 0. A byte read returns the selection in bit 0 with bits 7:1 zero. Every write to the port clears the key, function, bus, register offset and device, and leaves enable unchanged.
- R8: A 32-bit write to 0xCF8 never changes the method while the first method is active. While the second method is active, the same write applies byte 0 to the key/function register, byte 2 to the bus register and byte 3 to the mode port, in that order, so the mode write's clearing wins. A 32-bit read of 0xCF8 in the second method returns {mode byte, bus, 0xFF, key/function byte}.
- R9: The target slot is the device-table entry at (bus index, device), where the bus index is the bus-table entry for the bus number. No request is issued and reads return 0xFF when any of these holds: the bus-table entry is not below the number of bus indices, the device-table entry is not below the number of slots, or the slot's present bit is clear.
- R10: Table writes through the map port take effect for the next access. map_dev_tbl = 0 writes bus-table entry map_row, and writes to entry 0 are ignored. map_dev_tbl = 1 writes device-table entry (map_row, map_col), and rows at or above the number of bus indices are ignored.
- R11: Accesses that decode to nothing read all ones and leave all state unchanged. Examples are an unaligned 32-bit access, 0xCF9, unrelated ports, and byte access to 0xCF8..0xCFA in the first method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Host read cycle, one clock |
| io_wr | input | 1 | Host write cycle, one clock |
| io_dword | input | 1 | 1 = 32-bit access (aligned), 0 = byte access |
| io_wdata | input | 32 | Host write data; a byte access uses bits 7:0 |
| io_rdata | output | 32 | Host read data, valid in the read cycle |
| map_we | input | 1 | Route table write strobe |
| map_dev_tbl | input | 1 | 0 = bus table, 1 = device table |
| map_row | input | 8 | Bus number (bus table) or bus index (device table) |
| map_col | input | 5 | Device number for a device-table write |
| map_val | input | 8 | Entry value; 0xFF marks unmapped |
| slot_present | input | NUM_SLOTS | One bit per populated slot |
| cfg_req | output | 1 | Configuration request strobe |
| cfg_we | output | 1 | 1 = write request |
| cfg_bus | output | 8 | Requested bus number |
| cfg_dev | output | 5 | Requested device number |
| cfg_func | output | 3 | Requested function number |
| cfg_reg | output | 8 | Requested register byte address |
| cfg_slot | output | SLOT_W | Target slot index |
| cfg_wdata | output | 8 | Byte to write |
| cfg_rdata | input | 8 | Byte returned by the target slot |

## Verification
The reference model is exercised in both methods. In each, accesses target a mapped and populated slot, an empty slot, a device with no table entry, and a bus whose index is out of range, which separates translation faults from decode faults. Latch words with bits 30:24 set, and register offsets combined with every window byte, show whether field positions and the OR rule are right. Key-zero and enable-clear accesses show the gating. Sequences of mode writes, including 32-bit writes that cover the mode port in each method, distinguish correct clearing and ordering from a design that lets the mode port be overwritten.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam logic [15:0] PORT_ADDR = 16'h0CF8;
    localparam logic [15:0] PORT_BUS  = 16'h0CFA;
    localparam logic [15:0] PORT_MODE = 16'h0CFB;
    localparam logic [13:0] REG_QUAD  = 14'h033E;   // 0xCF8..0xCFB
    localparam logic [13:0] DATA_QUAD = 14'h033F;   // 0xCFC..0xCFF
    localparam logic [3:0]  WIN_PAGE  = 4'hC;       // 0xC000..0xCFFF

    typedef struct packed {
        logic [7:0] offs;
        logic [2:0] func;
        logic [4:0] dev;
        logic [7:0] bus;
        logic       en;
        logic [3:0] key;
        logic       mech1;
    } acc_state_t;

    typedef struct packed {
        logic       hit;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] func;
        logic [7:0] regno;
    } cfg_tgt_t;

endpackage

// File: rtl/cfg_host_decode.sv
module cfg_host_decode
    import cfg_pkg::*;
#(
    parameter bit SWITCHABLE = 1'b1
) (
    input  acc_state_t  st,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_dword,
    input  logic [31:0] io_wdata,
    output acc_state_t  st_d,
    output cfg_tgt_t    tgt,
    output logic [31:0] reg_rdata
);

    function automatic acc_state_t mode_write(acc_state_t s, logic sel1);
        acc_state_t r;
        r       = s;
        r.offs  = '0;
        r.func  = '0;
        r.dev   = '0;
        r.bus   = '0;
        r.key   = '0;
        r.mech1 = sel1;
        return r;
    endfunction

    logic       in_regs;
    logic       in_data;
    logic       is_byte;
    logic [7:0] mode_byte;
    logic [7:0] keyfunc;

    always_comb begin
        in_regs   = (io_addr[15:2] == REG_QUAD);
        in_data   = (io_addr[15:2] == DATA_QUAD);
        is_byte   = !io_dword;
        mode_byte = SWITCHABLE ? {7'b0, st.mech1} : 8'hFF;
        keyfunc   = {st.key, st.func, 1'b0};

        st_d      = st;
        tgt       = '0;
        reg_rdata = '1;

        // window decode
        if (is_byte) begin
            if (st.mech1) begin
                if (in_data && st.en) begin
                    tgt.hit   = 1'b1;
                    tgt.bus   = st.bus;
                    tgt.dev   = st.dev;
                    tgt.func  = st.func;
                    tgt.regno = st.offs | {6'b0, io_addr[1:0]};
                end
            end else if (st.key != 4'd0 && io_addr[15:12] == WIN_PAGE && !in_regs) begin
                tgt.hit   = 1'b1;
                tgt.bus   = st.bus;
                tgt.dev   = {1'b0, io_addr[11:8]};
                tgt.func  = st.func;
                tgt.regno = io_addr[7:0];
            end
        end

        // register port read data
        if (io_dword && io_addr == PORT_ADDR) begin
            if (st.mech1)
                reg_rdata = {st.en, 7'b0, st.bus, st.dev, st.func, st.offs};
            else
                reg_rdata = {mode_byte, st.bus, 8'hFF, keyfunc};
        end else if (is_byte) begin
            if (io_addr == PORT_MODE)
                reg_rdata = {24'hFFFFFF, mode_byte};
            else if (!st.mech1 && io_addr == PORT_ADDR)
                reg_rdata = {24'hFFFFFF, keyfunc};
            else if (!st.mech1 && io_addr == PORT_BUS)
                reg_rdata = {24'hFFFFFF, st.bus};
        end

        // register port writes
        if (io_wr) begin
            if (st.mech1) begin
                if (io_dword && io_addr == PORT_ADDR) begin
                    st_d.offs = io_wdata[7:0];
                    st_d.func = io_wdata[10:8];
                    st_d.dev  = io_wdata[15:11];
                    st_d.bus  = io_wdata[23:16];
                    st_d.en   = io_wdata[31];
                end else if (is_byte && io_addr == PORT_MODE && SWITCHABLE) begin
                    st_d = mode_write(st, io_wdata[0]);
                end
            end else if (io_dword && io_addr == PORT_ADDR) begin
                st_d.func = io_wdata[3:1];
                st_d.key  = io_wdata[7:4];
                st_d.bus  = io_wdata[23:16];
                if (SWITCHABLE)
                    st_d = mode_write(st_d, io_wdata[24]);
            end else if (is_byte) begin
                if (io_addr == PORT_ADDR) begin
                    st_d.func = io_wdata[3:1];
                    st_d.key  = io_wdata[7:4];
                end else if (io_addr == PORT_BUS) begin
                    st_d.bus = io_wdata[7:0];
                end else if (io_addr == PORT_MODE && SWITCHABLE) begin
                    st_d = mode_write(st, io_wdata[0]);
                end
            end
        end
    end

endmodule

// File: rtl/cfg_route_tables.sv
module cfg_route_tables #(
    parameter int NUM_SLOTS   = 32,
    parameter int NUM_BUS_IDX = 4,
    localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int BIDX_W     = (NUM_BUS_IDX > 1) ? $clog2(NUM_BUS_IDX) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 map_we,
    input  logic                 map_dev_tbl,
    input  logic [7:0]           map_row,
    input  logic [4:0]           map_col,
    input  logic [7:0]           map_val,
    input  logic [7:0]           bus,
    input  logic [4:0]           dev,
    input  logic [NUM_SLOTS-1:0] slot_present,
    output logic                 slot_ok,
    output logic [SLOT_W-1:0]    slot
);

    localparam int          NUM_DEVS = 32;
    localparam logic [7:0]  IDX_LIM  = 8'(NUM_BUS_IDX);
    localparam logic [8:0]  SLOT_LIM = 9'(NUM_SLOTS);

    typedef struct packed {
        logic [255:0][7:0]                        bus_map;
        logic [NUM_BUS_IDX-1:0][NUM_DEVS-1:0][7:0] dev_map;
    } tbl_t;

    tbl_t       tbl_d, tbl_q;
    logic [7:0] bidx;
    logic [7:0] sentry;
    logic       idx_ok;

    always_comb begin
        tbl_d = tbl_q;
        if (map_we) begin
            if (map_dev_tbl) begin
                if (map_row < IDX_LIM)
                    tbl_d.dev_map[map_row[BIDX_W-1:0]][map_col] = map_val;
            end else if (map_row != 8'd0) begin
                tbl_d.bus_map[map_row] = map_val;
            end
        end

        bidx    = tbl_q.bus_map[bus];
        idx_ok  = (bidx < IDX_LIM);
        sentry  = tbl_q.dev_map[bidx[BIDX_W-1:0]][dev];
        slot    = sentry[SLOT_W-1:0];
        slot_ok = idx_ok && ({1'b0, sentry} < SLOT_LIM) && slot_present[sentry[SLOT_W-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q            <= '1;
            tbl_q.bus_map[0] <= 8'd0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

endmodule

// File: rtl/cfg_access_decoder.sv
module cfg_access_decoder
    import cfg_pkg::*;
#(
    parameter int NUM_SLOTS   = 32,
    parameter int NUM_BUS_IDX = 4,
    parameter bit SWITCHABLE  = 1'b1,
    parameter bit FIXED_MECH1 = 1'b1,
    localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          io_addr,
    input  logic                 io_rd,
    input  logic                 io_wr,
    input  logic                 io_dword,
    input  logic [31:0]          io_wdata,
    output logic [31:0]          io_rdata,
    input  logic                 map_we,
    input  logic                 map_dev_tbl,
    input  logic [7:0]           map_row,
    input  logic [4:0]           map_col,
    input  logic [7:0]           map_val,
    input  logic [NUM_SLOTS-1:0] slot_present,
    output logic                 cfg_req,
    output logic                 cfg_we,
    output logic [7:0]           cfg_bus,
    output logic [4:0]           cfg_dev,
    output logic [2:0]           cfg_func,
    output logic [7:0]           cfg_reg,
    output logic [SLOT_W-1:0]    cfg_slot,
    output logic [7:0]           cfg_wdata,
    input  logic [7:0]           cfg_rdata
);

    localparam logic RESET_MECH1 = SWITCHABLE ? 1'b0 : FIXED_MECH1;

    acc_state_t  st_d, st_q;
    cfg_tgt_t    tgt;
    logic [31:0] reg_rdata;
    logic        slot_ok;

    cfg_host_decode #(
        .SWITCHABLE (SWITCHABLE)
    ) u_decode (
        .st        (st_q),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_dword  (io_dword),
        .io_wdata  (io_wdata),
        .st_d      (st_d),
        .tgt       (tgt),
        .reg_rdata (reg_rdata)
    );

    cfg_route_tables #(
        .NUM_SLOTS   (NUM_SLOTS),
        .NUM_BUS_IDX (NUM_BUS_IDX)
    ) u_tables (
        .clk          (clk),
        .rst_n        (rst_n),
        .map_we       (map_we),
        .map_dev_tbl  (map_dev_tbl),
        .map_row      (map_row),
        .map_col      (map_col),
        .map_val      (map_val),
        .bus          (tgt.bus),
        .dev          (tgt.dev),
        .slot_present (slot_present),
        .slot_ok      (slot_ok),
        .slot         (cfg_slot)
    );

    always_comb begin
        cfg_req   = (io_rd || io_wr) && tgt.hit && slot_ok;
        cfg_we    = io_wr;
        cfg_bus   = tgt.bus;
        cfg_dev   = tgt.dev;
        cfg_func  = tgt.func;
        cfg_reg   = tgt.regno;
        cfg_wdata = io_wdata[7:0];
        if (!io_rd)
            io_rdata = '1;
        else if (tgt.hit)
            io_rdata = slot_ok ? {24'hFFFFFF, cfg_rdata} : '1;
        else
            io_rdata = reg_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mech1 <= RESET_MECH1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_REQ_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (io_rd || io_wr)); // R3
    AST_REQ_SLOT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> slot_present[cfg_slot]); // R9
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mech1 && !st_q.en) |-> !cfg_req); // R4
    AST_KEY_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.mech1 && st_q.key == 4'd0) |-> !cfg_req); // R6
    AST_MODE_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (SWITCHABLE && io_wr && !io_dword && io_addr == PORT_MODE) |=>
        (st_q.key == 4'd0 && st_q.bus == 8'd0 && st_q.offs == 8'd0 &&
         st_q.dev == 5'd0 && st_q.func == 3'd0)); // R7
    AST_DWORD_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_dword && st_q.mech1) |=> st_q.mech1); // R8

endmodule

// File: tb/cfg_access_decoder_tb.sv
`timescale 1ns/100ps
module cfg_access_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_dword = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        map_we = 1'b0;
    logic        map_dev_tbl = 1'b0;
    logic [7:0]  map_row = '0;
    logic [4:0]  map_col = '0;
    logic [7:0]  map_val = '0;
    logic [31:0] slot_present = '0;
    logic        cfg_req, cfg_we;
    logic [7:0]  cfg_bus, cfg_reg, cfg_wdata, cfg_rdata;
    logic [4:0]  cfg_dev, cfg_slot;
    logic [2:0]  cfg_func;

    always #2.5 clk = ~clk;

    // slot model: returns register address plus slot number
    assign cfg_rdata = cfg_reg + {3'b0, cfg_slot};

    cfg_access_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_dword(io_dword), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .map_we(map_we), .map_dev_tbl(map_dev_tbl), .map_row(map_row),
        .map_col(map_col), .map_val(map_val), .slot_present(slot_present),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
        .cfg_func(cfg_func), .cfg_reg(cfg_reg), .cfg_slot(cfg_slot),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    int m_mech1, m_en, m_offs, m_func, m_dev, m_bus, m_key;
    int bmap[256];
    int dmap[4][32];

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    task automatic model_mode(input int v);
        m_offs = 0; m_func = 0; m_dev = 0; m_bus = 0; m_key = 0;
        m_mech1 = v & 1;
    endtask

    task automatic cyc(input bit wr, input bit rd, input bit dw, input logic [15:0] a,
                       input logic [31:0] d, input string tag);
        bit hit, ok;
        int b, dv, rg, bi, sl, ad;
        logic [31:0] exp_rd;
        io_wr = wr; io_rd = rd; io_dword = dw; io_addr = a; io_wdata = d;
        #2;
        ad = int'(a);
        hit = 0; b = 0; dv = 0; rg = 0; ok = 0; sl = 0;
        if (!dw) begin
            if (m_mech1 != 0) begin
                if (ad >= 'hCFC && ad <= 'hCFF && m_en != 0) begin
                    hit = 1; b = m_bus; dv = m_dev; rg = m_offs | (ad - 'hCFC);
                end
            end else if (m_key != 0 && ad >= 'hC000 && ad <= 'hCFFF && !(ad >= 'hCF8 && ad <= 'hCFB)) begin
                hit = 1; b = m_bus; dv = (ad >> 8) & 15; rg = ad & 255;
            end
        end
        if (hit) begin
            bi = bmap[b];
            if (bi < 4) begin
                sl = dmap[bi][dv];
                ok = (sl < 32) && slot_present[sl];
            end
        end
        if (!rd) exp_rd = 32'hFFFFFFFF;
        else if (hit) exp_rd = ok ? (32'hFFFFFF00 | ((rg + sl) & 255)) : 32'hFFFFFFFF;
        else if (dw && ad == 'hCF8) begin
            if (m_mech1 != 0)
                exp_rd = (m_en << 31) | (m_bus << 16) | (m_dev << 11) | (m_func << 8) | m_offs;
            else
                exp_rd = (m_mech1 << 24) | (m_bus << 16) | ('hFF << 8) | (m_key << 4) | (m_func << 1);
        end else if (!dw && ad == 'hCFB) exp_rd = 32'hFFFFFF00 | m_mech1;
        else if (!dw && m_mech1 == 0 && ad == 'hCF8) exp_rd = 32'hFFFFFF00 | (m_key << 4) | (m_func << 1);
        else if (!dw && m_mech1 == 0 && ad == 'hCFA) exp_rd = 32'hFFFFFF00 | m_bus;
        else exp_rd = 32'hFFFFFFFF;

        check(tag, "cfg_req", {31'b0, cfg_req}, {31'b0, (wr || rd) && ok});
        if ((wr || rd) && ok) begin
            check(tag, "cfg_bus", {24'b0, cfg_bus}, b);
            check(tag, "cfg_dev", {27'b0, cfg_dev}, dv);
            check(tag, "cfg_func", {29'b0, cfg_func}, m_func);
            check(tag, "cfg_reg", {24'b0, cfg_reg}, rg);
            check(tag, "cfg_slot", {27'b0, cfg_slot}, sl);
            check(tag, "cfg_we", {31'b0, cfg_we}, {31'b0, wr});
            if (wr) check(tag, "cfg_wdata", {24'b0, cfg_wdata}, d & 255);
        end
        if (rd) check(tag, "io_rdata", io_rdata, exp_rd);

        @(posedge clk);
        if (wr) begin
            if (m_mech1 != 0) begin
                if (dw && ad == 'hCF8) begin
                    m_offs = d & 255; m_func = (d >> 8) & 7; m_dev = (d >> 11) & 31;
                    m_bus = (d >> 16) & 255; m_en = (d >> 31) & 1;
                end else if (!dw && ad == 'hCFB) model_mode(d & 255);
            end else if (dw && ad == 'hCF8) begin
                m_func = (d >> 1) & 7; m_key = (d >> 4) & 15; m_bus = (d >> 16) & 255;
                model_mode((d >> 24) & 255);
            end else if (!dw) begin
                if (ad == 'hCF8) begin m_func = (d >> 1) & 7; m_key = (d >> 4) & 15; end
                else if (ad == 'hCFA) m_bus = d & 255;
                else if (ad == 'hCFB) model_mode(d & 255);
            end
        end
        #1;
        io_wr = 0; io_rd = 0; io_dword = 0;
    endtask

    task automatic map_wr(input bit devt, input int row, input int col, input int val);
        map_we = 1; map_dev_tbl = devt; map_row = 8'(row); map_col = 5'(col); map_val = 8'(val);
        @(posedge clk);
        if (devt) begin if (row < 4) dmap[row][col] = val; end
        else if (row != 0) bmap[row] = val;
        #1;
        map_we = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_mech1 = 0; m_en = 0; m_offs = 0; m_func = 0; m_dev = 0; m_bus = 0; m_key = 0;
        for (int i = 0; i < 256; i++) bmap[i] = 'hFF;
        bmap[0] = 0;
        for (int i = 0; i < 4; i++) for (int j = 0; j < 32; j++) dmap[i][j] = 'hFF;
        slot_present = (32'h1 << 5) | (32'h1 << 12);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        cyc(0, 1, 0, 16'h0CFB, 0, "R1");
        cyc(0, 1, 0, 16'h0CF8, 0, "R1");
        cyc(0, 1, 0, 16'h0CFA, 0, "R1");
        cyc(0, 1, 0, 16'h0C000, 0, "R1");

        // R10 table setup
        map_wr(1, 0, 3, 5);
        map_wr(1, 0, 4, 7);     // slot 7 not present
        map_wr(0, 9, 0, 2);
        map_wr(1, 2, 3, 12);
        map_wr(0, 20, 0, 6);    // index out of range
        map_wr(1, 5, 3, 1);     // row beyond indices: ignored
        map_wr(0, 0, 0, 1);     // bus 0 entry fixed

        // R5 / R6 second method
        cyc(0, 1, 0, 16'hC310, 0, "R6");
        cyc(1, 0, 0, 16'h0CF8, 32'h35, "R5");
        cyc(0, 1, 0, 16'h0CF8, 0, "R5");
        cyc(0, 1, 0, 16'hC310, 0, "R10");
        cyc(1, 0, 0, 16'hC310, 32'h5A, "R6");
        cyc(1, 0, 0, 16'h0CFA, 32'h09, "R6");
        cyc(0, 1, 0, 16'h0CFA, 0, "R6");
        cyc(0, 1, 0, 16'hC320, 0, "R9");
        cyc(0, 1, 0, 16'hC400, 0, "R9");
        cyc(1, 0, 0, 16'h0CFA, 32'h14, "R9");
        cyc(0, 1, 0, 16'hC310, 0, "R9");
        cyc(1, 0, 0, 16'h0CFA, 32'h00, "R9");
        cyc(0, 1, 0, 16'hC4FF, 0, "R9");
        cyc(0, 1, 0, 16'h0CF9, 0, "R11");
        cyc(0, 1, 0, 16'h0CFC, 0, "R6");
        cyc(0, 1, 1, 16'h0CF8, 0, "R8");
        cyc(1, 0, 0, 16'h0CF8, 32'h02, "R6");
        cyc(0, 1, 0, 16'hC310, 0, "R6");
        cyc(1, 0, 0, 16'hC310, 32'h11, "R6");

        // R7 switch to first method
        cyc(1, 0, 0, 16'h0CF8, 32'hF4, "R7");
        cyc(1, 0, 0, 16'h0CFA, 32'h09, "R7");
        cyc(1, 0, 0, 16'h0CFB, 32'h01, "R7");
        cyc(0, 1, 0, 16'h0CFB, 0, "R7");
        cyc(0, 1, 1, 16'h0CF8, 0, "R7");

        // R2 latch
        cyc(1, 0, 1, 16'h0CF8, 32'h80001A40, "R2");
        cyc(0, 1, 1, 16'h0CF8, 0, "R2");
        cyc(1, 0, 1, 16'h0CF8, 32'hFF091A40, "R8");
        cyc(0, 1, 1, 16'h0CF8, 0, "R2");
        cyc(0, 1, 0, 16'h0CFB, 0, "R8");

        // R3 data window
        cyc(0, 1, 0, 16'h0CFD, 0, "R3");
        cyc(1, 0, 0, 16'h0CFE, 32'h77, "R3");
        cyc(1, 0, 1, 16'h0CF8, 32'h80001A43, "R3");
        cyc(0, 1, 0, 16'h0CFF, 0, "R3");
        cyc(0, 1, 0, 16'h0CFC, 0, "R3");
        cyc(1, 0, 1, 16'h0CF8, 32'h80002200, "R9");
        cyc(0, 1, 0, 16'h0CFC, 0, "R9");

        // R11 no-decode accesses
        cyc(0, 1, 0, 16'h0CF8, 0, "R11");
        cyc(1, 0, 0, 16'h0CFA, 32'h33, "R11");
        cyc(0, 1, 1, 16'h0CF9, 0, "R11");
        cyc(1, 0, 1, 16'h0CF9, 32'h0, "R11");
        cyc(0, 1, 0, 16'h0080, 0, "R11");
        cyc(0, 1, 1, 16'h0CF8, 0, "R11");

        // R4 enable clear
        cyc(1, 0, 1, 16'h0CF8, 32'h00001A40, "R4");
        cyc(0, 1, 0, 16'h0CFC, 0, "R4");
        cyc(1, 0, 0, 16'h0CFD, 32'h12, "R4");

        // R8 dword write in second method
        cyc(1, 0, 1, 16'h0CF8, 32'h80001A40, "R8");
        cyc(1, 0, 0, 16'h0CFB, 32'h00, "R7");
        cyc(0, 1, 0, 16'h0CFB, 0, "R7");
        cyc(0, 1, 1, 16'h0CF8, 0, "R7");
        cyc(1, 0, 1, 16'h0CF8, 32'h00090035, "R8");
        cyc(0, 1, 0, 16'h0CF8, 0, "R8");
        cyc(0, 1, 0, 16'h0CFA, 0, "R8");
        cyc(0, 1, 0, 16'h0CFB, 0, "R8");
        cyc(1, 0, 1, 16'h0CF8, 32'h01090035, "R8");
        cyc(0, 1, 0, 16'h0CFB, 0, "R8");
        cyc(0, 1, 1, 16'h0CF8, 0, "R8");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule